// File: doc/BRIEF.md
# Interrupt Priority Level Evaluator

This block merges two sources of interrupt requests into one priority decision. Software requests come from a request mask, where each bit in a fixed window stands for one software level. External requests come from a set of hardware lines, where each bit position is the level itself. The block works out the single highest level among all pending requests and a summary vector with every pending bit at its own position. It then compares that level against the current interrupt priority level of the processor.

When the pending level is nonzero and strictly above the current priority, the block raises a one-cycle take strobe. In the same clock edge it captures the summary vector and the winning level into two registers that the interrupt handler reads. Evaluation is not continuous. A check-pending flag allows one evaluation and is then cleared. A pulse marking the return from a handler sets the flag again, so the requests are re-examined after each return. The flag is set out of reset, so the first cycle after reset is an evaluation.

Top module: `irq_level_eval`

## Requirements
- R1: A software request bit i, for i from 4 to 18 of `sw_req_i`, stands for level i-3, so the window covers levels 1 to 15.
- R2: An external request bit i, for i from 20 to 30 of `ext_req_i`, stands for level i.
- R3: The evaluated level is the highest level among all pending requests, and any pending external request wins over every software request.
- R4: The summary vector carries a 1 at the bit position of every pending in-window request from either source, and 0 elsewhere.
- R5: Request bits outside the two windows (software bits 0-3 and 19-31, external bits 0-19 and 31) have no effect on the level, the summary or the take strobe.
- R6: An evaluation takes an interrupt only when the level is nonzero and strictly greater than `cur_ipl_i` (5 bits). An equal level is not taken.
- R7: On a taken interrupt `summary_o` and `int_id_o` are loaded with the summary and the level. Otherwise both registers keep their values.
- R8: An evaluation happens on a clock edge only while the check-pending flag is set, and the flag is cleared by that edge. Requests that arrive while the flag is clear are not taken.
- R9: `hret_i` high at a clock edge sets the check-pending flag for the next edge. If the pulse coincides with an evaluation, the flag stays set and a second evaluation follows.
- R10: Reset (synchronous, active high) clears `take_o`, `summary_o` and `int_id_o` and sets the check-pending flag.
- R11: `take_o`, `summary_o` and `int_id_o` are registers that change on the evaluating clock edge. `take_o` is high for exactly one cycle per taken evaluation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req_i | input | 32 | Software request mask, bits 4..18 used |
| ext_req_i | input | 32 | External request lines, bits 20..30 used |
| cur_ipl_i | input | 5 | Current interrupt priority level |
| hret_i | input | 1 | Handler-return pulse, re-arms evaluation |
| take_o | output | 1 | One-cycle take-interrupt strobe |
| summary_o | output | 32 | Captured interrupt summary vector |
| int_id_o | output | 5 | Captured interrupt level |

## Verification
The assertions assume that `cur_ipl_i` is stable across the cycle that precedes an evaluating edge. They also assume that no output is trusted while reset is high. The bench respects this by changing the requests and the priority only on falling edges, and by changing them only when no evaluation is due on the next rising edge, except in the deliberate case of a handler-return pulse held over two edges. Requests outside the windows are driven with wide patterns so that the summary checks can show that those bits are dropped.

// File: rtl/irq_eval_pkg.sv
package irq_eval_pkg;

    localparam int SUM_W   = 32;
    localparam int LVL_W   = 5;
    localparam int SW_LO   = 4;
    localparam int SW_HI   = 18;
    localparam int SW_BIAS = SW_LO - 1;
    localparam int EXT_LO  = 20;
    localparam int EXT_HI  = 30;

    typedef logic [SUM_W-1:0] sum_t;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic found;
        lvl_t lvl;
        sum_t sum;
    } scan_t;

    typedef struct packed {
        logic take;
        lvl_t lvl;
        sum_t sum;
    } verdict_t;

    function automatic sum_t window_mask(input int lo, input int hi);
        sum_t m;
        m = '0;
        for (int i = 0; i < SUM_W; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic lvl_beats(input lvl_t lvl, input lvl_t ipl);
        return (lvl != '0) && (lvl > ipl);
    endfunction

endpackage

// File: rtl/irq_req_scan.sv
module irq_req_scan
    import irq_eval_pkg::*;
#(
    parameter int LO   = 4,
    parameter int HI   = 18,
    parameter int BIAS = 3
) (
    input  sum_t  req_i,
    output scan_t res_o
);
    localparam sum_t WIN = window_mask(LO, HI);

    sum_t kept;

    genvar g;
    generate
        for (g = 0; g < SUM_W; g++) begin : g_keep
            assign kept[g] = req_i[g] & WIN[g];
        end
    endgenerate

    always_comb begin
        res_o = '0;
        res_o.sum = kept;
        for (int i = LO; i <= HI; i++) begin
            if (kept[i]) begin
                res_o.found = 1'b1;
                res_o.lvl   = lvl_t'(i - BIAS);
            end
        end
    end
endmodule

// File: rtl/irq_lvl_merge.sv
module irq_lvl_merge
    import irq_eval_pkg::*;
(
    input  scan_t    sw_i,
    input  scan_t    ext_i,
    input  lvl_t     ipl_i,
    output verdict_t vd_o
);
    always_comb begin
        vd_o.sum  = sw_i.sum | ext_i.sum;
        vd_o.lvl  = ext_i.found ? ext_i.lvl : sw_i.lvl;
        vd_o.take = lvl_beats(vd_o.lvl, ipl_i);
    end
endmodule

// File: rtl/irq_take_ctl.sv
module irq_take_ctl
    import irq_eval_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_t vd_i,
    input  logic     hret_i,
    output logic     pend_o,
    output logic     take_o,
    output sum_t     sum_o,
    output lvl_t     lvl_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b1;
            take_o <= 1'b0;
            sum_o  <= '0;
            lvl_o  <= '0;
        end else begin
            take_o <= 1'b0;
            if (pend_q && vd_i.take) begin
                take_o <= 1'b1;
                sum_o  <= vd_i.sum;
                lvl_o  <= vd_i.lvl;
            end
            pend_q <= hret_i;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_level_eval.sv
module irq_level_eval
    import irq_eval_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      sw_req_i,
    input  logic [31:0]      ext_req_i,
    input  logic [4:0]       cur_ipl_i,
    input  logic             hret_i,
    output logic             take_o,
    output logic [31:0]      summary_o,
    output logic [4:0]       int_id_o
);
    scan_t    sw_scan;
    scan_t    ext_scan;
    verdict_t verdict;
    logic     chk_pend;

    irq_req_scan #(.LO(SW_LO), .HI(SW_HI), .BIAS(SW_BIAS)) u_sw_scan (
        .req_i (sw_req_i),
        .res_o (sw_scan)
    );

    irq_req_scan #(.LO(EXT_LO), .HI(EXT_HI), .BIAS(0)) u_ext_scan (
        .req_i (ext_req_i),
        .res_o (ext_scan)
    );

    irq_lvl_merge u_merge (
        .sw_i  (sw_scan),
        .ext_i (ext_scan),
        .ipl_i (cur_ipl_i),
        .vd_o  (verdict)
    );

    irq_take_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .vd_i   (verdict),
        .hret_i (hret_i),
        .pend_o (chk_pend),
        .take_o (take_o),
        .sum_o  (summary_o),
        .lvl_o  (int_id_o)
    );
endmodule

// File: rtl/irq_level_eval_chk.sv
module irq_level_eval_chk
    import irq_eval_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [4:0]  cur_ipl_i,
    input logic        hret_i,
    input logic        take_o,
    input logic [31:0] summary_o,
    input logic [4:0]  int_id_o,
    input logic        chk_pend
);
    localparam sum_t VALID = window_mask(SW_LO, SW_HI) | window_mask(EXT_LO, EXT_HI);

    // R6
    take_above_prior_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (int_id_o != '0) && (int_id_o > $past(cur_ipl_i)));

    // R7
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> $stable(summary_o) && $stable(int_id_o));

    // R4
    level_in_summary_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> ((int'(int_id_o) >= EXT_LO) ? summary_o[int'(int_id_o)]
                                               : summary_o[int'(int_id_o) + SW_BIAS]));

    // R5
    summary_window_chk: assert property (@(posedge clk) disable iff (rst)
        (summary_o & ~VALID) == '0);

    // R9
    hret_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        $past(hret_i) |-> chk_pend);

    // R8
    idle_no_take_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_pend |=> !take_o);
endmodule

bind irq_level_eval irq_level_eval_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cur_ipl_i (cur_ipl_i),
    .hret_i    (hret_i),
    .take_o    (take_o),
    .summary_o (summary_o),
    .int_id_o  (int_id_o),
    .chk_pend  (chk_pend)
);

// File: tb/tb_irq_level_eval.sv
module tb_irq_level_eval;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] sw_req_i  = '0;
    logic [31:0] ext_req_i = '0;
    logic [4:0]  cur_ipl_i = '0;
    logic        hret_i    = 1'b0;
    logic        take_o;
    logic [31:0] summary_o;
    logic [4:0]  int_id_o;

    irq_level_eval dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int unsigned due;
        logic        take;
        logic [31:0] sum;
        logic [4:0]  id;
        string       tag;
    } item_t;

    item_t       sb[$];
    int unsigned cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 0;
    logic [31:0] m_sum = '0;
    logic [4:0]  m_id  = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            n_cmp++;
            if (take_o !== it.take || summary_o !== it.sum || int_id_o !== it.id) begin
                n_bad++;
                $display("FAIL %s: take=%0b sum=%h id=%0d expected take=%0b sum=%h id=%0d",
                         it.tag, take_o, summary_o, int_id_o, it.take, it.sum, it.id);
            end
        end
    end

    function automatic void model(input logic [31:0] sw, input logic [31:0] ext,
                                  output logic [4:0] lvl, output logic [31:0] sum);
        lvl = '0;
        sum = '0;
        for (int i = 4; i <= 18; i++) if (sw[i]) begin lvl = 5'(i - 3); sum[i] = 1'b1; end
        for (int i = 20; i <= 30; i++) if (ext[i]) begin lvl = 5'(i); sum[i] = 1'b1; end
    endfunction

    task automatic push(input int unsigned due, input logic tk, input string tag);
        item_t it;
        it.due = due; it.take = tk; it.sum = m_sum; it.id = m_id; it.tag = tag;
        sb.push_back(it);
    endtask

    // arm with a handler-return pulse of h cycles, expect h evaluations
    task automatic arm(input logic [31:0] sw, input logic [31:0] ext,
                       input logic [4:0] ipl, input int h, input string tag);
        logic [4:0]  lvl;
        logic [31:0] sum;
        logic        tk;
        int unsigned k;
        @(negedge clk);
        k = cyc;
        sw_req_i = sw; ext_req_i = ext; cur_ipl_i = ipl; hret_i = 1'b1;
        model(sw, ext, lvl, sum);
        tk = (lvl != 0) && (lvl > ipl);
        for (int e = 0; e < h; e++) begin
            if (tk) begin m_sum = sum; m_id = lvl; end
            push(k + 2 + e, tk, tag);
        end
        push(k + h + 2, 1'b0, tag);
        repeat (h) @(negedge clk);
        hret_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // change inputs with no re-arm; nothing may be taken
    task automatic quiet(input logic [31:0] sw, input logic [31:0] ext,
                         input logic [4:0] ipl, input int n, input string tag);
        int unsigned k;
        @(negedge clk);
        k = cyc;
        sw_req_i = sw; ext_req_i = ext; cur_ipl_i = ipl;
        for (int e = 1; e <= n; e++) push(k + e, 1'b0, tag);
        repeat (n + 1) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        n_cmp++;
        if (take_o !== 1'b0 || summary_o !== '0 || int_id_o !== '0) begin
            n_bad++;
            $display("FAIL R10: take=%0b sum=%h id=%0d expected 0/0/0", take_o, summary_o, int_id_o);
        end
        rst = 1'b0;
        // R10 evaluation right after reset with nothing pending
        push(cyc + 1, 1'b0, "R10");
        repeat (3) @(negedge clk);

        arm(32'h0000_0010, '0, 5'd0, 1, "R1 sw bit4 lvl1");
        arm(32'h0004_0000, '0, 5'd0, 1, "R1 sw bit18 lvl15");
        arm(32'h0000_1220, '0, 5'd0, 1, "R3 R4 sw highest");
        arm('0, 32'h0010_0000, 5'd19, 1, "R2 ext bit20");
        arm(32'h0004_0000, 32'h4040_0000, 5'd0, 1, "R3 R4 ext beats sw");
        arm(32'h0000_0400, '0, 5'd7, 1, "R6 equal not taken");
        arm(32'h0000_0400, '0, 5'd6, 1, "R6 above taken");
        arm(32'hFFF8_000F, 32'h800F_FFFF, 5'd0, 1, "R5 out of window");
        arm(32'hFFF8_004F, 32'h800F_FFFF, 5'd0, 1, "R5 masked with sw6");
        arm('0, '0, 5'd0, 1, "R6 zero level");
        quiet('0, 32'h0200_0000, 5'd0, 4, "R8 no rearm");
        arm('0, 32'h0200_0000, 5'd0, 1, "R8 after rearm");
        arm(32'h0000_0100, 32'h0000_0000, 5'd2, 2, "R9 R11 double eval");
        arm('0, 32'h4000_0000, 5'd31, 1, "R6 max ipl");
        arm(32'h0000_8000, 32'h0000_0000, 5'd11, 1, "R7 R11 load");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R11: %0d expected items left, expected 0", sb.size());
        end
        done = 1;
        finish_up();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
            finish_up();
        end
    end
endmodule